// File: doc/BRIEF.md
# I2C Master Status and Interrupt Register Unit

This unit holds the status, extended status, mode and interrupt-enable registers of an I2C master. It also drives the master's single interrupt line. The shifting engine and the data buffer sit outside this unit. They report to it through single-cycle event pulses (transfer finished, bus halted, transfer error, successful start) and through live level inputs (transfer pending, buffer full, buffer holding data, bus busy). The unit turns these inputs into readable status fields.

Software reaches the unit through a byte-wide register port. The port has one write strobe and a combinational read path. Clear-on-write-one fields use a fixed clear mask for each register. The mode register keeps only its defined bits. A command location triggers a soft reset that returns every register here to its reset value.

The interrupt is a registered level. It rises one cycle after a qualified completion or halt event. A qualified event needs both the global enable in the mode register and the matching bit in the enable mask. The line falls only when software writes the active flag to status while the global enable is set.

Top module: `stat_irq_unit`

## Requirements
- R1: After reset the status reads 0 (with all live inputs low), mode reads 0, mask reads 0, extended status reads 0x40 with the bus free, and `irq` is 0.
- R2: The status register (address 0) is laid out as follows. Bit 0 mirrors `xfer_pending`, bit 4 mirrors `buf_full` and bit 5 mirrors `buf_has_data`. Bit 1 is the interrupt-active flag. Bit 2 is the error flag: `ev_err` sets it, `ev_start_ok` clears it, and `ev_err` wins when both occur.
- R3: A write to status clears only stored bits that are set in both the written value and 0x0A. The error bit survives a write of 0xFF.
- R4: Extended status (address 1) reads bits 6:4 as 4 while `bus_busy` is 0 and as 5 while it is 1. Bit 0 is an abort flag that `ev_err` sets. A write clears bits set in both the value and 0x8F.
- R5: A write to mode (address 2) stores the value ANDed with 0x3D. Mode bit 2 is the global interrupt enable.
- R6: The interrupt mask (address 3) stores and reads back all 8 written bits.
- R7: `ev_done` with the global enable and mask bit 0 both set raises status bit 1 and `irq` on the next cycle. Without both bits it has no effect.
- R8: `ev_halt` with the global enable and mask bit 3 both set raises status bit 1 and `irq` on the next cycle. Without both bits it has no effect.
- R9: A status write with bit 1 set clears the active flag in every case. It lowers `irq` only while the global enable is set.
- R10: When a qualified event and a clearing status write fall in the same cycle, the flag and `irq` end up set.
- R11: A write to address 4 with bit 0 set resets mode, mask, the stored status flags, the abort flag and `irq` to 0. A write there with bit 0 clear changes nothing. Address 4 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| bus_busy | input | 1 | Bus busy level from the bus engine |
| xfer_pending | input | 1 | Transfer pending level |
| buf_full | input | 1 | Data buffer full level |
| buf_has_data | input | 1 | Data buffer non-empty level |
| ev_done | input | 1 | Pulse: transfer finished with at least one byte |
| ev_halt | input | 1 | Pulse: busy bus was halted |
| ev_err | input | 1 | Pulse: transfer error or abort |
| ev_start_ok | input | 1 | Pulse: start condition acknowledged |
| irq | output | 1 | Interrupt line, registered level |

## Verification
Completion and halt events are applied under each combination of global enable and per-source mask bit. This shows whether each source is gated by its own mask bit and not by the other one.

Clearing writes are issued with the enable on and with it off. These separate clearing the flag from lowering the line. A clear that coincides with a new event checks the set priority.

Writes of all-ones and of single bits to each register tell the clear and keep masks apart. Soft-reset writes with bit 0 low and with it high show that the reset is triggered by that bit alone.

// File: rtl/stat_irq_pkg.sv
package stat_irq_pkg;
  localparam int DW = 8;
  localparam int AW = 3;
  localparam int CODE_W = 3;

  localparam logic [DW-1:0] STS_CLR_MASK   = 8'h0A;
  localparam logic [DW-1:0] EXT_CLR_MASK   = 8'h8F;
  localparam logic [DW-1:0] MODE_KEEP_MASK = 8'h3D;

  localparam logic [CODE_W-1:0] BUS_FREE_CODE = 3'd4;
  localparam logic [CODE_W-1:0] BUS_BUSY_CODE = 3'd5;

  localparam int GEN_EN_BIT   = 2;
  localparam int MSK_DONE_BIT = 0;
  localparam int MSK_HALT_BIT = 3;
  localparam int SRST_BIT     = 0;

  typedef enum logic [AW-1:0] {
    A_STS  = 3'd0,
    A_EXT  = 3'd1,
    A_MODE = 3'd2,
    A_MASK = 3'd3,
    A_SRST = 3'd4
  } reg_addr_e;

  function automatic logic [DW-1:0] f_mode_keep(input logic [DW-1:0] w);
    return w & MODE_KEEP_MASK;
  endfunction

  function automatic logic [DW-1:0] f_sts_view(input logic pend, input logic act,
                                              input logic err, input logic full,
                                              input logic has);
    logic [DW-1:0] v;
    v = '0;
    v[0] = pend; v[1] = act; v[2] = err; v[4] = full; v[5] = has;
    return v;
  endfunction

  function automatic logic [DW-1:0] f_ext_view(input logic busy, input logic abort);
    logic [DW-1:0] v;
    v = '0;
    v[6:4] = busy ? BUS_BUSY_CODE : BUS_FREE_CODE;
    v[0] = abort;
    return v;
  endfunction
endpackage

// File: rtl/sirq_ctrl.sv
module sirq_ctrl
  import stat_irq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          mode_we,
  input  logic          mask_we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] mode_q,
  output logic [DW-1:0] mask_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      mask_q <= '0;
    end else if (soft_rst) begin
      mode_q <= '0;
      mask_q <= '0;
    end else begin
      if (mode_we) mode_q <= f_mode_keep(wdata);
      if (mask_we) mask_q <= wdata;
    end
  end
endmodule

// File: rtl/sirq_line.sv
module sirq_line
  import stat_irq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          gen_en,
  input  logic [DW-1:0] mask_q,
  input  logic          ev_done,
  input  logic          ev_halt,
  input  logic          clr_req,
  output logic          set_evt,
  output logic          irq
);
  logic lower_req;

  assign set_evt   = gen_en & ((ev_done & mask_q[MSK_DONE_BIT]) |
                               (ev_halt & mask_q[MSK_HALT_BIT]));
  assign lower_req = clr_req & gen_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         irq <= 1'b0;
    else if (soft_rst)  irq <= 1'b0;
    else if (set_evt)   irq <= 1'b1;
    else if (lower_req) irq <= 1'b0;
  end
endmodule

// File: rtl/sirq_status.sv
module sirq_status
  import stat_irq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          set_evt,
  input  logic          sts_we,
  input  logic          ext_we,
  input  logic [DW-1:0] wdata,
  input  logic          ev_err,
  input  logic          ev_start_ok,
  output logic          act_flag,
  output logic          err_flag,
  output logic          abort_flag
);
  logic [DW-1:0] sts_clr, ext_clr;

  assign sts_clr = sts_we ? (wdata & STS_CLR_MASK) : '0;
  assign ext_clr = ext_we ? (wdata & EXT_CLR_MASK) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_flag   <= 1'b0;
      err_flag   <= 1'b0;
      abort_flag <= 1'b0;
    end else if (soft_rst) begin
      act_flag   <= 1'b0;
      err_flag   <= 1'b0;
      abort_flag <= 1'b0;
    end else begin
      if (set_evt)         act_flag <= 1'b1;
      else if (sts_clr[1]) act_flag <= 1'b0;
      if (ev_err)           err_flag <= 1'b1;
      else if (ev_start_ok) err_flag <= 1'b0;
      if (ev_err)          abort_flag <= 1'b1;
      else if (ext_clr[0]) abort_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/stat_irq_unit.sv
module stat_irq_unit
  import stat_irq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          bus_busy,
  input  logic          xfer_pending,
  input  logic          buf_full,
  input  logic          buf_has_data,
  input  logic          ev_done,
  input  logic          ev_halt,
  input  logic          ev_err,
  input  logic          ev_start_ok,
  output logic          irq
);
  logic          soft_rst, sts_we, ext_we, mode_we, mask_we, clr_req, set_evt;
  logic [DW-1:0] mode_q, mask_q;
  logic          act_flag, err_flag, abort_flag;

  assign sts_we   = wr_en && (addr == A_STS);
  assign ext_we   = wr_en && (addr == A_EXT);
  assign mode_we  = wr_en && (addr == A_MODE);
  assign mask_we  = wr_en && (addr == A_MASK);
  assign soft_rst = wr_en && (addr == A_SRST) && wdata[SRST_BIT];
  assign clr_req  = sts_we && wdata[1] && STS_CLR_MASK[1];

  sirq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .mode_we(mode_we), .mask_we(mask_we), .wdata(wdata),
    .mode_q(mode_q), .mask_q(mask_q)
  );

  sirq_line u_line (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .gen_en(mode_q[GEN_EN_BIT]), .mask_q(mask_q),
    .ev_done(ev_done), .ev_halt(ev_halt), .clr_req(clr_req),
    .set_evt(set_evt), .irq(irq)
  );

  sirq_status u_status (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .set_evt(set_evt),
    .sts_we(sts_we), .ext_we(ext_we), .wdata(wdata),
    .ev_err(ev_err), .ev_start_ok(ev_start_ok),
    .act_flag(act_flag), .err_flag(err_flag), .abort_flag(abort_flag)
  );

  always_comb begin
    case (addr)
      A_STS:   rdata = f_sts_view(xfer_pending, act_flag, err_flag, buf_full, buf_has_data);
      A_EXT:   rdata = f_ext_view(bus_busy, abort_flag);
      A_MODE:  rdata = mode_q;
      A_MASK:  rdata = mask_q;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/stat_irq_unit_chk.sv
module stat_irq_unit_chk
  import stat_irq_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] rdata,
  input logic          bus_busy,
  input logic          ev_done,
  input logic          ev_halt,
  input logic          set_evt,
  input logic          act_flag,
  input logic [DW-1:0] mode_q,
  input logic [DW-1:0] mask_q,
  input logic          irq
);
  logic srst_wr;
  assign srst_wr = wr_en && (addr == A_SRST) && wdata[SRST_BIT];

  assert_rise_needs_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(ev_done || ev_halt));

  assert_fall_needs_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(wr_en && ((addr == A_STS && wdata[1] && mode_q[GEN_EN_BIT]) ||
                                   (addr == A_SRST && wdata[SRST_BIT]))));

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (set_evt && !srst_wr) |=> (irq && act_flag));

  assert_bus_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_EXT) |-> (rdata[6:4] == (bus_busy ? BUS_BUSY_CODE : BUS_FREE_CODE)));

  assert_mode_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q & ~MODE_KEEP_MASK) == '0);

  assert_soft_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
    srst_wr |=> (mode_q == '0 && mask_q == '0 && !irq && !act_flag));
endmodule

bind stat_irq_unit stat_irq_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .bus_busy(bus_busy), .ev_done(ev_done), .ev_halt(ev_halt),
  .set_evt(set_evt), .act_flag(act_flag), .mode_q(mode_q), .mask_q(mask_q),
  .irq(irq)
);

// File: tb/stat_irq_unit_test.sv
module stat_irq_unit_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic bus_busy = 0, xfer_pending = 0, buf_full = 0, buf_has_data = 0;
  logic ev_done = 0, ev_halt = 0, ev_err = 0, ev_start_ok = 0;
  logic irq;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  stat_irq_unit uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .bus_busy(bus_busy), .xfer_pending(xfer_pending),
    .buf_full(buf_full), .buf_has_data(buf_has_data), .ev_done(ev_done),
    .ev_halt(ev_halt), .ev_err(ev_err), .ev_start_ok(ev_start_ok), .irq(irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic pulse_done(); @(negedge clk); ev_done = 1; @(negedge clk); ev_done = 0; endtask
  task automatic pulse_halt(); @(negedge clk); ev_halt = 1; @(negedge clk); ev_halt = 0; endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(0, v); chk("R1 status", v, 8'h00);
    rd(1, v); chk("R1 ext", v, 8'h40);
    rd(2, v); chk("R1 mode", v, 8'h00);
    rd(3, v); chk("R1 mask", v, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_status_layout();
    logic [7:0] v;
    xfer_pending = 1; buf_full = 1; buf_has_data = 1;
    rd(0, v); chk("R2 live bits", v, 8'h31);
    xfer_pending = 0; buf_full = 0; buf_has_data = 0;
    @(negedge clk); ev_err = 1; @(negedge clk); ev_err = 0;
    rd(0, v); chk("R2 error set", v, 8'h04);
    wr(0, 8'hFF);
    rd(0, v); chk("R3 error kept", v, 8'h04);
    @(negedge clk); ev_start_ok = 1; @(negedge clk); ev_start_ok = 0;
    rd(0, v); chk("R2 error cleared", v, 8'h00);
  endtask

  task automatic t_ext();
    logic [7:0] v;
    bus_busy = 1; rd(1, v); chk("R4 busy code", v, 8'h51);
    bus_busy = 0; rd(1, v); chk("R4 free code", v, 8'h41);
    wr(1, 8'hFE); rd(1, v); chk("R4 no-clear", v, 8'h41);
    wr(1, 8'h01); rd(1, v); chk("R4 abort cleared", v, 8'h40);
  endtask

  task automatic t_regs();
    logic [7:0] v;
    wr(2, 8'hFF); rd(2, v); chk("R5 mode keep", v, 8'h3D);
    wr(3, 8'hA5); rd(3, v); chk("R6 mask", v, 8'hA5);
  endtask

  task automatic t_done();
    logic [7:0] v;
    wr(2, 8'h04); wr(3, 8'h01);
    pulse_done();
    chk("R7 irq up", {7'd0, irq}, 8'h01);
    rd(0, v); chk("R7 flag", v, 8'h02);
    wr(0, 8'h02);
    chk("R9 irq down", {7'd0, irq}, 8'h00);
    wr(3, 8'h08); pulse_done();
    chk("R7 other mask", {7'd0, irq}, 8'h00);
    wr(3, 8'h01); wr(2, 8'h00); pulse_done();
    chk("R7 gen off", {7'd0, irq}, 8'h00);
    rd(0, v); chk("R7 no flag", v, 8'h00);
  endtask

  task automatic t_halt();
    logic [7:0] v;
    wr(2, 8'h04); wr(3, 8'h08);
    pulse_halt();
    chk("R8 irq up", {7'd0, irq}, 8'h01);
    rd(0, v); chk("R8 flag", v, 8'h02);
    wr(0, 8'h02);
    wr(3, 8'h01); pulse_halt();
    chk("R8 other mask", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_lower();
    logic [7:0] v;
    wr(2, 8'h04); wr(3, 8'h01); pulse_done();
    wr(2, 8'h00); wr(0, 8'h02);
    rd(0, v); chk("R9 flag cleared gen off", v, 8'h00);
    chk("R9 irq held gen off", {7'd0, irq}, 8'h01);
    wr(2, 8'h04); wr(0, 8'h02);
    chk("R9 irq lowered", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_collide();
    logic [7:0] v;
    @(negedge clk); wr_en = 1; addr = 0; wdata = 8'h02; ev_done = 1;
    @(negedge clk); wr_en = 0; ev_done = 0;
    chk("R10 irq set wins", {7'd0, irq}, 8'h01);
    rd(0, v); chk("R10 flag set wins", v, 8'h02);
  endtask

  task automatic t_srst();
    logic [7:0] v;
    wr(4, 8'hFE);
    rd(2, v); chk("R11 no reset mode", v, 8'h04);
    chk("R11 no reset irq", {7'd0, irq}, 8'h01);
    rd(4, v); chk("R11 reads zero", v, 8'h00);
    @(negedge clk); ev_err = 1; @(negedge clk); ev_err = 0;
    wr(4, 8'h01);
    rd(2, v); chk("R11 mode", v, 8'h00);
    rd(3, v); chk("R11 mask", v, 8'h00);
    rd(0, v); chk("R11 status", v, 8'h00);
    rd(1, v); chk("R11 ext", v, 8'h40);
    chk("R11 irq", {7'd0, irq}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_status_layout();
    t_ext();
    t_regs();
    t_done();
    t_halt();
    t_lower();
    t_collide();
    t_srst();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog (all requirements) actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule